// File: doc/BRIEF.md
# Synchronous Serial Port Controller

A register-mapped serial master. A host writes words into a transmit queue through a data register. A transfer engine moves each word through a mode-0 serial shifter and stores the word that comes back in a receive queue. The host then pops that queue through the same data register. Both queues hold eight entries. The word length is programmable from 1 to 16 bits, and each word is masked to that length on the way in and on the way back. A loopback mode sends each transmitted word straight into the receive queue and leaves the serial pins idle. This lets software test the data path without a connected device.

Status flags report the fill state of both queues and whether the engine is busy. Two level-based interrupt sources are provided: receive at least half full, and transmit at most half full. They are masked and ORed onto a single interrupt line. The engine never starts a word while the receive queue is full. It waits until the host drains an entry, so no received word is ever lost.

Top module: `serial_port_ctrl`

## Requirements
- R1: After reset both queues are empty, the mask register reads 0, the raw interrupt register (word 0x18) reads 0x08, the status register (word 0x0C) reads 0x03, the masked interrupt register (word 0x1C) reads 0 and `irq` is low.
- R2: Bits 3:0 of control word 0 (offset 0x00) hold the word length minus one. Words pushed into the transmit queue are masked to that length, and so are words stored in the receive queue.
- R3: A write to the data register (offset 0x08) appends the masked word to the transmit queue. The write is dropped when the queue already holds 8 words. Words are sent in the order they were written.
- R4: A read of the data register returns the oldest received word and removes it. When the receive queue is empty the read returns 0 and changes no state.
- R5: The status register has five bits: bit0 set when the transmit queue is empty, bit1 set when it is not full, bit2 set when the receive queue is not empty, bit3 set when it is full, and bit4 (busy) set while the transmit queue holds data or a word is shifting.
- R6: Raw interrupt bit2 is 1 when the receive queue holds 4 or more words, and bit3 is 1 when the transmit queue holds 4 or fewer. The interrupt mask sits at offset 0x14, and offset 0x1C reads raw AND mask. `irq` is high exactly when that AND is nonzero.
- R7: A word starts only while control word 1 (offset 0x04) bit1 (enable) is set and the receive queue holds fewer than 8 words. Otherwise the words stay queued until the blocking condition clears.
- R8: When control word 1 bit0 (loopback) is set, each transmitted word is stored unchanged in the receive queue, and the pins stay idle: `spi_cs_n` high, `spi_sclk` and `spi_mosi` low.
- R9: Outside loopback, a word is shifted MSB first in mode 0 with exactly as many clock pulses as the word length. `spi_miso` is sampled on each rising `spi_sclk`. Each half period of `spi_sclk` lasts max(prescale, 2) system clocks, and the first rising edge comes that many clocks after `spi_cs_n` falls.
- R10: `spi_cs_n` is low for the whole of each word. It stays low between back-to-back words and returns high once the transmit queue is empty after a word ends.
- R11: Offsets 0xFE0 to 0xFFC read one identification byte per word, taken from the ID_BYTES parameter least-significant byte first. The prescale register (offset 0x10) keeps 8 bits. Reads of unmapped offsets, including 0x20, return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bus_sel | input | 1 | register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | byte offset of the access |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, valid in the access cycle |
| irq | output | 1 | combined masked interrupt |
| spi_sclk | output | 1 | serial clock, idles low |
| spi_mosi | output | 1 | serial data out |
| spi_miso | input | 1 | serial data in |
| spi_cs_n | output | 1 | active-low chip select |

## Verification
The bench builds the block with its default values: 8-entry queues, 16-bit words and an 8-bit prescaler. With these values the queues reach full, the interrupt thresholds sit at exactly four entries, and word lengths can be drawn across the whole 1 to 16 range. Loopback fills the receive queue to force the receive-full stall. Random word lengths and prescale values from 0 to 4 cover the clamp at 2 and its absence. A bench device returns the inverse of each bit it receives, so a received word never equals the transmitted one.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;
  // word index (byte offset >> 2) of each register
  localparam logic [9:0] IDX_CTRL0 = 10'h000;
  localparam logic [9:0] IDX_CTRL1 = 10'h001;
  localparam logic [9:0] IDX_DATA  = 10'h002;
  localparam logic [9:0] IDX_STAT  = 10'h003;
  localparam logic [9:0] IDX_PRESC = 10'h004;
  localparam logic [9:0] IDX_IMASK = 10'h005;
  localparam logic [9:0] IDX_IRAW  = 10'h006;
  localparam logic [9:0] IDX_IMSK  = 10'h007;
  localparam logic [6:0] ID_PAGE   = 7'h7F;   // byte offsets 0xFE0..0xFFF

  localparam int B_LOOP = 0;
  localparam int B_EN   = 1;

  // mask of the low (field+1) bits
  function automatic logic [31:0] size_mask(input logic [3:0] field);
    return (32'd1 << (32'(field) + 32'd1)) - 32'd1;
  endfunction

  // half period of the serial clock, clamped to at least 2 system clocks
  function automatic logic [7:0] half_period(input logic [7:0] ps);
    return (ps < 8'd2) ? 8'd2 : ps;
  endfunction
endpackage

// File: rtl/sp_fifo.sv
module sp_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             empty,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (count == '0));
endmodule

// File: rtl/sp_shifter.sv
module sp_shifter #(
  parameter int WORD_W = 16,
  parameter int PS_W   = 8,
  localparam int NB_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  input  logic [NB_W-1:0]   nbits,
  input  logic [PS_W-1:0]   half,
  input  logic              lpbk,
  input  logic              more,
  input  logic              miso,
  output logic              active,
  output logic              done,
  output logic [WORD_W-1:0] rx_word,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n
);
  logic [WORD_W-1:0] sreg, rsreg, wkeep;
  logic [PS_W-1:0]   cnt, half_q;
  logic [NB_W-1:0]   left;
  logic              lp_q, edge_now;

  assign edge_now = active && (cnt == half_q - 1'b1);
  assign done     = edge_now && sclk && (left == '0);
  assign rx_word  = lp_q ? wkeep : rsreg;
  assign mosi     = sreg[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; sclk <= 1'b0; cs_n <= 1'b1; cnt <= '0; half_q <= PS_W'(2);
      left <= '0; sreg <= '0; rsreg <= '0; wkeep <= '0; lp_q <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
      sclk   <= 1'b0;
      cs_n   <= 1'b0;
      sreg   <= word << (NB_W'(WORD_W) - nbits);
      rsreg  <= '0;
      wkeep  <= word;
      left   <= nbits - 1'b1;
      half_q <= half;
      lp_q   <= lpbk;
    end else if (active) begin
      cnt <= edge_now ? '0 : cnt + 1'b1;
      if (edge_now) begin
        if (!sclk) begin
          sclk  <= 1'b1;
          rsreg <= {rsreg[WORD_W-2:0], miso};
        end else if (left == '0) begin
          active <= 1'b0;
          sclk   <= 1'b0;
          cs_n   <= !more;
        end else begin
          sclk <= 1'b0;
          sreg <= sreg << 1;
          left <= left - 1'b1;
        end
      end
    end else if (!more) begin
      cs_n <= 1'b1;
    end
  end

  assert_cs_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !cs_n);
  assert_sclk_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sclk);
endmodule

// File: rtl/serial_port_ctrl.sv
module serial_port_ctrl
  import serial_port_pkg::*;
#(
  parameter int          DEPTH    = 8,
  parameter int          WORD_W   = 16,
  parameter logic [63:0] ID_BYTES = 64'h3CA5_0FE1_0007_2491,
  localparam int         CW       = $clog2(DEPTH + 1),
  localparam int         NB_W     = $clog2(WORD_W + 1),
  localparam int         HALF     = DEPTH / 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        spi_cs_n
);
  logic [15:0] cr0;
  logic [3:0]  cr1, imask;
  logic [7:0]  presc;
  logic [9:0]  widx;
  logic        wr_hit, rd_data;
  logic [WORD_W-1:0] wmask, tx_head, rx_head, rx_word;
  logic [CW-1:0]     tx_cnt, rx_cnt;
  logic tx_empty, tx_full, rx_empty, rx_full;
  logic shift_start, shift_active, shift_done, more, busy;
  logic sh_sclk, sh_mosi, sh_cs_n;
  logic [3:0] iraw;

  assign widx    = bus_addr[11:2];
  assign wr_hit  = bus_sel && bus_wr;
  assign rd_data = bus_sel && !bus_wr && (widx == IDX_DATA);
  assign wmask   = WORD_W'(size_mask(cr0[3:0]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr0 <= 16'd7; cr1 <= '0; presc <= '0; imask <= '0;
    end else if (wr_hit) begin
      case (widx)
        IDX_CTRL0: cr0   <= bus_wdata[15:0];
        IDX_CTRL1: cr1   <= bus_wdata[3:0];
        IDX_PRESC: presc <= bus_wdata[7:0];
        IDX_IMASK: imask <= bus_wdata[3:0];
        default: ;
      endcase
    end
  end

  sp_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) i_txq (
    .clk, .rst_n,
    .push(wr_hit && (widx == IDX_DATA)), .wdata(bus_wdata[WORD_W-1:0] & wmask),
    .pop(shift_start), .head(tx_head), .count(tx_cnt), .empty(tx_empty), .full(tx_full));

  sp_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) i_rxq (
    .clk, .rst_n,
    .push(shift_done), .wdata(rx_word & wmask),
    .pop(rd_data), .head(rx_head), .count(rx_cnt), .empty(rx_empty), .full(rx_full));

  assign more        = cr1[B_EN] && !tx_empty;
  assign shift_start = more && !rx_full && !shift_active;
  assign busy        = !tx_empty || shift_active;

  sp_shifter #(.WORD_W(WORD_W), .PS_W(8)) i_shift (
    .clk, .rst_n, .start(shift_start), .word(tx_head),
    .nbits(NB_W'(cr0[3:0]) + 1'b1), .half(half_period(presc)),
    .lpbk(cr1[B_LOOP]), .more(more), .miso(spi_miso),
    .active(shift_active), .done(shift_done), .rx_word(rx_word),
    .sclk(sh_sclk), .mosi(sh_mosi), .cs_n(sh_cs_n));

  assign spi_sclk = sh_sclk && !cr1[B_LOOP];
  assign spi_mosi = sh_mosi && !cr1[B_LOOP];
  assign spi_cs_n = sh_cs_n || cr1[B_LOOP];

  assign iraw = {tx_cnt <= CW'(HALF), rx_cnt >= CW'(HALF), 2'b00};
  assign irq  = |(iraw & imask);

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[11:5] == ID_PAGE) begin
      bus_rdata = {24'd0, ID_BYTES[8*bus_addr[4:2] +: 8]};
    end else begin
      case (widx)
        IDX_CTRL0: bus_rdata = {16'd0, cr0};
        IDX_CTRL1: bus_rdata = {28'd0, cr1};
        IDX_DATA:  bus_rdata = rx_empty ? '0 : 32'(rx_head);
        IDX_STAT:  bus_rdata = {27'd0, busy, rx_full, !rx_empty, !tx_full, tx_empty};
        IDX_PRESC: bus_rdata = {24'd0, presc};
        IDX_IMASK: bus_rdata = {28'd0, imask};
        IDX_IRAW:  bus_rdata = {28'd0, iraw};
        IDX_IMSK:  bus_rdata = {28'd0, iraw & imask};
        default:   bus_rdata = '0;
      endcase
    end
  end

  assert_rx_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    shift_start |-> (cr1[B_EN] && (rx_cnt < CW'(DEPTH))));
  assert_rx_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    shift_done |-> !rx_full);
  assert_loop_pins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cr1[B_LOOP] && shift_active) |=> $stable(spi_cs_n) || !cr1[B_LOOP]);
endmodule

// File: tb/test_serial_port_ctrl.sv
module test_serial_port_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, spi_sclk, spi_mosi, spi_miso, spi_cs_n;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  serial_port_ctrl i_serial_port_ctrl (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .irq, .spi_sclk, .spi_mosi, .spi_miso, .spi_cs_n);

  always #10 clk = ~clk;   // 20-unit period, 50 MHz
  assign spi_miso = ~spi_mosi;   // device answers with inverted bits

  // serial monitor
  logic [15:0] cap = '0;
  int rises = 0, cs_falls = 0, cs_rises = 0;
  longint t_cs = 0, t_rise = 0;
  bit first_pending = 0;
  always @(posedge spi_sclk) begin
    cap = {cap[14:0], spi_mosi};
    rises++;
    if (first_pending) begin t_rise = $time; first_pending = 0; end
  end
  always @(negedge spi_cs_n) begin cs_falls++; t_cs = $time; first_pending = 1; end
  always @(posedge spi_cs_n) cs_rises++;

  function automatic logic [31:0] lenmask(input int f);
    return 32'hFFFF >> (15 - f);
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int k = 0; k < 5000; k++) begin
      rd(12'h00C, s);
      if (!s[4]) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog R7 got=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] words [9];
    logic [31:0] extra [3];
    logic [31:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd_chk("R1 status", 12'h00C, 32'h03);
    rd_chk("R1 raw", 12'h018, 32'h08);
    rd_chk("R1 mask", 12'h014, 32'h00);
    rd_chk("R1 masked", 12'h01C, 32'h00);
    check("R1 irq", {31'd0, irq}, 32'd0);

    // R11 identification, unmapped, prescale width
    rd_chk("R11 id0", 12'hFE0, 32'h91);
    rd_chk("R11 id7", 12'hFFC, 32'h3C);
    rd_chk("R11 id3", 12'hFEC, 32'h00);
    wr(12'h024, 32'hFFFF_FFFF);
    rd_chk("R11 unmapped", 12'h024, 32'h0);
    rd_chk("R11 dma", 12'h020, 32'h0);
    rd_chk("R11 ctrl1 untouched", 12'h004, 32'h0);
    wr(12'h010, 32'h1FF);
    rd_chk("R11 prescale", 12'h010, 32'hFF);
    wr(12'h010, 32'h0);

    // R4 empty pop
    rd_chk("R4 empty read", 12'h008, 32'h0);
    rd_chk("R4 status unchanged", 12'h00C, 32'h03);

    // fill transmit queue while disabled, 8-bit words
    wr(12'h000, 32'h7);
    wr(12'h004, 32'h0);
    for (int i = 0; i < 9; i++) begin
      words[i] = $urandom;
      wr(12'h008, words[i]);
    end
    rd_chk("R5 tx full status", 12'h00C, 32'h10);
    rd_chk("R6 raw tx full", 12'h018, 32'h00);
    wr(12'h014, 32'h0C);
    check("R6 irq low", {31'd0, irq}, 32'd0);

    // loopback drains into receive queue
    cs_falls = 0;
    wr(12'h004, 32'h3);
    wait_idle();
    rd_chk("R5 rx full status", 12'h00C, 32'h0F);
    rd_chk("R6 raw rx full", 12'h018, 32'h0C);
    rd_chk("R6 masked", 12'h01C, 32'h0C);
    check("R6 irq high", {31'd0, irq}, 32'd1);
    check("R8 pins idle", {30'd0, spi_cs_n, spi_sclk}, 32'h2);
    check("R8 no select", cs_falls, 0);
    wr(12'h014, 32'h04);
    rd_chk("R6 masked part", 12'h01C, 32'h04);
    wr(12'h014, 32'h00);
    check("R6 irq masked off", {31'd0, irq}, 32'd0);

    // R7 stall on full receive queue
    for (int i = 0; i < 3; i++) begin
      extra[i] = $urandom;
      wr(12'h008, extra[i]);
    end
    repeat (200) @(negedge clk);
    rd_chk("R7 stalled status", 12'h00C, 32'h1E);
    for (int i = 0; i < 8; i++) begin
      rd(12'h008, v);
      check("R3 R2 order and mask", v, words[i] & 32'hFF);
      repeat (80) @(negedge clk);
    end
    for (int i = 0; i < 3; i++) begin
      rd(12'h008, v);
      check("R7 resumed word", v, extra[i] & 32'hFF);
      repeat (80) @(negedge clk);
    end
    rd_chk("R3 ninth dropped", 12'h008, 32'h0);
    rd_chk("R5 idle status", 12'h00C, 32'h03);

    // R9 random normal-mode words
    wr(12'h004, 32'h2);
    for (int n = 0; n < 16; n++) begin
      int f, p, hp;
      logic [31:0] w;
      f = (n == 0) ? 0 : ((n == 1) ? 15 : int'($urandom_range(0, 15)));
      p = int'($urandom_range(0, 4));
      hp = (p < 2) ? 2 : p;
      w = $urandom;
      wr(12'h000, 32'(f));
      wr(12'h010, 32'(p));
      cap = '0; rises = 0; cs_rises = 0;
      wr(12'h008, w);
      wait_idle();
      check("R9 pulse count", rises, f + 1);
      check("R9 msb first", 32'(cap) & lenmask(f), w & lenmask(f));
      check("R9 half period", 32'(t_rise - t_cs), 32'(hp * 20));
      check("R10 release", cs_rises, 1);
      rd(12'h008, v);
      check("R2 R9 received", v, ~w & lenmask(f));
    end

    // R10 back-to-back words keep select low
    wr(12'h004, 32'h0);
    wr(12'h000, 32'h7);
    wr(12'h010, 32'h3);
    wr(12'h008, 32'h5A);
    wr(12'h008, 32'hC3);
    cs_falls = 0; cs_rises = 0;
    wr(12'h004, 32'h2);
    repeat (10) @(negedge clk);
    check("R10 select low", {31'd0, spi_cs_n}, 32'd0);
    wait_idle();
    check("R10 one fall", cs_falls, 1);
    check("R10 one rise", cs_rises, 1);
    rd_chk("R10 word a", 12'h008, 32'hA5);
    rd_chk("R10 word b", 12'h008, 32'h3C);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule